// File: doc/BRIEF.md
# Ring Oscillator Length Controller

This block converts a run-time length setting into the control signals of a ring oscillator whose loop is built from bypassable two-inverter stages. A loop-closing NAND gate provides the final inversion when it is enabled. Each stage has a bypass multiplexer and a gating demultiplexer. The controller picks the one stage whose multiplexer closes the loop. It turns on the inputs of the stages inside the loop and leaves every stage past that point gated off, so no unused inverter toggles. It also drives the NAND enable and an optional divide-by-two toggle flip-flop on the oscillator output.

A length write is checked before use. An even value, or one below three, is rejected: the previous setting stays and an error pulse lasts one clock. An accepted value is staged. It reaches the stage controls only on a clock edge at which the oscillator is disabled, so the loop never changes length while it runs.

The inverter loop itself is not part of the block. A clocked stand-in models it: each active inverter counts as one clock of delay, so the ring level toggles every L clocks for a length of L.

Top module: `ring_len_ctrl`

## Requirements
- R1: A write of an odd length L with 3 <= L <= 255, made while `osc_en` is low, is accepted. Two clock edges after the write, `stage_sel` has only bit (L-3)/2 set, so bit 0 means the three-inverter base loop.
- R2: A write of an even length, or of a length below 3, leaves `stage_sel` unchanged. `len_err` is high for exactly the one cycle that follows the write edge. An accepted write leaves `len_err` low.
- R3: `stage_sel` always has exactly one bit set.
- R4: `stage_gate[k]` is 1 exactly when `osc_en` is 1 and k is not above the selected index, so the number of set bits is index+1. While `osc_en` is 0, all gate bits are 0.
- R5: A length accepted while `osc_en` is high does not change `stage_sel` while the enable stays high. It is applied on the first clock edge at which `osc_en` is sampled low.
- R6: `nand_en` follows `osc_en`. After a clock edge with `osc_en` low, the undivided ring level is 1.
- R7: With `div_sel` = 0, the output falls L clock edges after the first edge that samples `osc_en` high. It then toggles every L edges, for a period of 2L clocks.
- R8: With `div_sel` = 1, the output is a toggle flip-flop that flips on each rising transition of the ring level. This gives a period of 4L clocks, and the first rise comes 2L edges after enable.
- R9: The toggle flip-flop is cleared to 0 on any clock edge that samples `osc_en` low, so a divided output reads 0 while disabled.
- R10: `div_sel` may change at any time. It selects between the ring level and the toggle flip-flop without any clock delay.
- R11: After reset, the selected length is 3 (index 0), `len_err` is 0, the ring level is 1 and the toggle flip-flop is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_en | input | 1 | Oscillator run enable |
| len_wr | input | 1 | One-cycle strobe that offers `len_in` |
| len_in | input | LEN_W | Requested loop length in inverters |
| div_sel | input | 1 | 1 selects the divide-by-two output |
| stage_sel | output | 2**(LEN_W-1)-1 | One-hot bypass multiplexer select |
| stage_gate | output | 2**(LEN_W-1)-1 | Per-stage input gating enables |
| nand_en | output | 1 | Enable of the loop-closing NAND gate |
| len_err | output | 1 | One-cycle rejection pulse |
| osc_out | output | 1 | Oscillator output, direct or divided |

## Verification
The bench builds the block with its defaults: an 8-bit length and 127 stages. This makes both ends of the range reachable. The bench checks the shortest loop, with only the base loop gated on, and the longest loop, with every gate on and a 510-clock period. Because the ring stand-in turns inverter count into clock counts, the bench can predict every output edge exactly. It uses this to check the divided and undivided waveforms, the staging of writes made while running, and the clearing of the divider on disable.

// File: rtl/rolc_pkg.sv
// Package: shared types and sizing helpers for the ring length controller.
// Assumes lengths are unsigned and counted in inverters.
package rolc_pkg;

    // Result of checking a requested loop length
    typedef enum logic [1:0] {
        LEN_OK    = 2'd0,
        LEN_SHORT = 2'd1,
        LEN_EVEN  = 2'd2
    } len_chk_e;

    // Number of two-inverter stages reachable with a length field of len_w bits
    function automatic int stage_count(input int len_w);
        return (1 << (len_w - 1)) - 1;
    endfunction

endpackage

// File: rtl/rolc_len_gate.sv
// Module: validates length writes and stages them.
// A valid write goes to a pending register. The applied length copies the
// pending one only on edges where the oscillator is disabled.
// Assumes RESET_LEN is odd and at least 3.
module rolc_len_gate #(
    parameter int LEN_W     = 8,
    parameter int RESET_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_in,
    output logic [LEN_W-1:0] act_len,
    output logic             len_err
);
    import rolc_pkg::*;

    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(3);
    localparam logic [LEN_W-1:0] RST_LEN = LEN_W'(RESET_LEN);

    len_chk_e         chk;
    logic [LEN_W-1:0] pend_len;

    // Classify the offered length
    always_comb begin
        if (len_in < MIN_LEN)
            chk = LEN_SHORT;
        else if (!len_in[0])
            chk = LEN_EVEN;
        else
            chk = LEN_OK;
    end

    // Hold the pending value, the applied value and the error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_len <= RST_LEN;
            act_len  <= RST_LEN;
            len_err  <= 1'b0;
        end else begin
            len_err <= len_wr && (chk != LEN_OK);
            if (len_wr && (chk == LEN_OK))
                pend_len <= len_in;
            if (!osc_en)
                act_len <= pend_len;
        end
    end

endmodule

// File: rtl/rolc_stage_dec.sv
// Module: turns the applied length into a one-hot bypass select and
// thermometer gating enables. Stage k is in the loop when k <= (L-3)/2.
// Assumes act_len is odd and at least 3.
module rolc_stage_dec #(
    parameter int LEN_W = 8,
    parameter int NST   = 127
) (
    input  logic             osc_en,
    input  logic [LEN_W-1:0] act_len,
    output logic [NST-1:0]   stage_sel,
    output logic [NST-1:0]   stage_gate
);
    localparam int IDX_W = LEN_W - 1;

    logic [IDX_W-1:0] idx;

    // Stage index from the inverter count
    always_comb idx = IDX_W'((act_len - LEN_W'(3)) >> 1);

    for (genvar k = 0; k < NST; k++) begin : g_stage
        localparam logic [IDX_W-1:0] KV = IDX_W'(k);
        // One multiplexer closes the loop; gates open up to and including it
        always_comb begin
            stage_sel[k]  = (idx == KV);
            stage_gate[k] = osc_en && (KV <= idx);
        end
    end

endmodule

// File: rtl/rolc_ring_model.sv
// Module: clocked stand-in for the inverter loop. Each active inverter
// counts as one clock of delay, so the level toggles every act_len clocks.
// While disabled, the NAND output is forced high and the level rests at 1.
// Assumes act_len does not change while osc_en is high.
module rolc_ring_model #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic [LEN_W-1:0] act_len,
    output logic             ring_lvl,
    output logic             ring_rise
);
    logic [LEN_W-1:0] cnt;
    logic             last;

    // Last delay step of the current half period
    always_comb last = (cnt == act_len - LEN_W'(1));

    // Ring level is about to go from 0 to 1
    always_comb ring_rise = osc_en && last && !ring_lvl;

    // Advance the delay count and toggle at the end of each half period
    always_ff @(posedge clk) begin
        if (!rst_n || !osc_en) begin
            cnt      <= '0;
            ring_lvl <= 1'b1;
        end else if (last) begin
            cnt      <= '0;
            ring_lvl <= !ring_lvl;
        end else begin
            cnt <= cnt + LEN_W'(1);
        end
    end

endmodule

// File: rtl/rolc_out_div.sv
// Module: optional divide-by-two toggle stage and the output selector.
// The flip-flop flips on each rising ring transition and is cleared while
// the oscillator is disabled. Assumes ring_rise coincides with the edge
// on which the ring level rises.
module rolc_out_div (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic ring_lvl,
    input  logic ring_rise,
    input  logic div_sel,
    output logic osc_out
);
    logic tgl_q;

    // Toggle on each ring rise, clear when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !osc_en)
            tgl_q <= 1'b0;
        else if (ring_rise)
            tgl_q <= !tgl_q;
    end

    // Select direct or divided output
    always_comb osc_out = div_sel ? tgl_q : ring_lvl;

endmodule

// File: rtl/ring_len_ctrl.sv
// Module: top of the adjustable ring oscillator length controller.
// Connects length validation, stage decoding, the loop stand-in and the
// output divider. Assumes a single clock and a synchronous active-low reset.
module ring_len_ctrl #(
    parameter int LEN_W     = 8,
    parameter int RESET_LEN = 3,
    localparam int NST      = rolc_pkg::stage_count(LEN_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_in,
    input  logic             div_sel,
    output logic [NST-1:0]   stage_sel,
    output logic [NST-1:0]   stage_gate,
    output logic             nand_en,
    output logic             len_err,
    output logic             osc_out
);
    logic [LEN_W-1:0] act_len;
    logic             ring_lvl;
    logic             ring_rise;

    // Loop-closing gate follows the run enable
    always_comb nand_en = osc_en;

    rolc_len_gate #(.LEN_W(LEN_W), .RESET_LEN(RESET_LEN)) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_en (osc_en),
        .len_wr (len_wr),
        .len_in (len_in),
        .act_len(act_len),
        .len_err(len_err)
    );

    rolc_stage_dec #(.LEN_W(LEN_W), .NST(NST)) u_dec (
        .osc_en    (osc_en),
        .act_len   (act_len),
        .stage_sel (stage_sel),
        .stage_gate(stage_gate)
    );

    rolc_ring_model #(.LEN_W(LEN_W)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .act_len  (act_len),
        .ring_lvl (ring_lvl),
        .ring_rise(ring_rise)
    );

    rolc_out_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .ring_lvl (ring_lvl),
        .ring_rise(ring_rise),
        .div_sel  (div_sel),
        .osc_out  (osc_out)
    );

endmodule

// File: rtl/rolc_checks.sv
// Module: protocol checks for ring_len_ctrl, bound to every instance.
// Observes only top-level ports.
module rolc_checks #(
    parameter int NST = 127
) (
    input logic           clk,
    input logic           rst_n,
    input logic           len_wr,
    input logic           div_sel,
    input logic [NST-1:0] stage_sel,
    input logic [NST-1:0] stage_gate,
    input logic           nand_en,
    input logic           len_err,
    input logic           osc_out
);
    // R3: exactly one bypass multiplexer closes the loop
    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stage_sel) == 1);

    // R4: no stage is gated on while the loop is stopped
    a_r4_gate_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_en |-> (stage_gate == '0));

    // R4: the selected stage is always inside the gated region when running
    a_r4_gate_covers: assert property (@(posedge clk) disable iff (!rst_n)
        nand_en |-> ((stage_gate & stage_sel) != '0));

    // R2: an error pulse only follows a write
    a_r2_err_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> $past(len_wr));

    // R5: the loop length stays put while the oscillator runs
    a_r5_hold_running: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nand_en) && $past(rst_n)) |-> $stable(stage_sel));

    // R6: undivided output rests high after an idle edge
    a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(nand_en) && !div_sel) |-> osc_out);

    // R9: divided output is cleared after an idle edge
    a_r9_div_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(nand_en) && div_sel) |-> !osc_out);

endmodule

bind ring_len_ctrl rolc_checks #(.NST(NST)) u_rolc_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_wr    (len_wr),
    .div_sel   (div_sel),
    .stage_sel (stage_sel),
    .stage_gate(stage_gate),
    .nand_en   (nand_en),
    .len_err   (len_err),
    .osc_out   (osc_out)
);

// File: tb/ring_len_ctrl_test.sv
`timescale 1ns/1ps
// Bench: scoreboard for ring_len_ctrl. The driver queues expected items
// with the cycle in which they are due; a monitor checks them on falling edges.
module ring_len_ctrl_test;
    localparam int LEN_W = 8;
    localparam int NST   = (1 << (LEN_W - 1)) - 1;

    localparam int K_SEL  = 0;
    localparam int K_POP  = 1;
    localparam int K_GATE = 2;
    localparam int K_OSC  = 3;
    localparam int K_ERR  = 4;
    localparam int K_EN   = 5;

    typedef struct {
        int due;
        int req;
        int kind;
        int val;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             osc_en = 1'b0;
    logic             len_wr = 1'b0;
    logic [LEN_W-1:0] len_in = '0;
    logic             div_sel = 1'b0;
    logic [NST-1:0]   stage_sel;
    logic [NST-1:0]   stage_gate;
    logic             nand_en;
    logic             len_err;
    logic             osc_out;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t q[$];

    ring_len_ctrl #(.LEN_W(LEN_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_en    (osc_en),
        .len_wr    (len_wr),
        .len_in    (len_in),
        .div_sel   (div_sel),
        .stage_sel (stage_sel),
        .stage_gate(stage_gate),
        .nand_en   (nand_en),
        .len_err   (len_err),
        .osc_out   (osc_out)
    );

    always #10 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    function automatic int sel_index(input logic [NST-1:0] v);
        for (int i = 0; i < NST; i++)
            if (v[i]) return i;
        return -1;
    endfunction

    task automatic compare(input exp_t e);
        int act;
        case (e.kind)
            K_SEL:   act = sel_index(stage_sel);
            K_POP:   act = $countones(stage_sel);
            K_GATE:  act = $countones(stage_gate);
            K_OSC:   act = int'(osc_out);
            K_ERR:   act = int'(len_err);
            default: act = int'(nand_en);
        endcase
        total++;
        if (act != e.val) begin
            bad++;
            $display("FAIL R%0d kind=%0d cycle=%0d actual=%0d expected=%0d",
                     e.req, e.kind, cyc, act, e.val);
        end
    endtask

    // Monitor: check all items due in this cycle
    initial forever begin
        exp_t rest[$];
        @(negedge clk);
        rest = {};
        foreach (q[i]) begin
            if (q[i].due == cyc) compare(q[i]);
            else rest.push_back(q[i]);
        end
        q = rest;
    end

    task automatic expect_at(input int req, input int kind, input int val, input int dly);
        exp_t e;
        e.due = cyc + dly;
        e.req = req;
        e.kind = kind;
        e.val = val;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_len(input int len);
        len_wr = 1'b1;
        len_in = LEN_W'(len);
        step(1);
        len_wr = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        summary();
    end

    // Driver
    initial begin
        step(4);
        rst_n = 1'b1;
        // R11: reset state
        expect_at(11, K_SEL, 0, 1);
        expect_at(11, K_POP, 1, 1);
        expect_at(11, K_OSC, 1, 1);
        expect_at(11, K_ERR, 0, 1);
        expect_at(11, K_GATE, 0, 1);
        step(2);
        div_sel = 1'b1;
        expect_at(9, K_OSC, 0, 1);    // R9 divider clear while idle
        step(1);
        div_sel = 1'b0;
        step(1);

        // R1: valid lengths map to (L-3)/2
        expect_at(2, K_ERR, 0, 1);    // R2 no error for a valid write
        expect_at(1, K_SEL, 3, 2);
        expect_at(3, K_POP, 1, 2);    // R3
        wr_len(9);
        step(2);
        // R2: even value rejected
        expect_at(2, K_ERR, 1, 1);
        expect_at(2, K_ERR, 0, 2);
        expect_at(2, K_SEL, 3, 3);
        wr_len(10);
        step(3);
        // R2: value below 3 rejected
        expect_at(2, K_ERR, 1, 1);
        expect_at(2, K_SEL, 3, 3);
        wr_len(1);
        step(3);
        expect_at(1, K_SEL, 126, 2);  // R1 maximum
        wr_len(255);
        step(2);
        expect_at(1, K_SEL, 0, 2);    // R1 minimum
        wr_len(3);
        step(2);
        expect_at(1, K_SEL, 1, 2);
        wr_len(5);
        step(2);

        // R7: run at L=5, direct output
        osc_en = 1'b1;
        expect_at(6, K_EN, 1, 1);     // R6
        expect_at(4, K_GATE, 2, 1);   // R4
        expect_at(7, K_OSC, 1, 4);
        expect_at(7, K_OSC, 0, 5);
        expect_at(7, K_OSC, 0, 9);
        expect_at(7, K_OSC, 1, 10);
        step(3);
        // R5: write while running is held back
        expect_at(5, K_SEL, 1, 2);
        expect_at(5, K_SEL, 1, 6);
        expect_at(4, K_GATE, 2, 6);
        wr_len(7);
        step(8);
        osc_en = 1'b0;
        expect_at(5, K_SEL, 2, 1);    // R5 applied on the idle edge
        expect_at(4, K_GATE, 0, 1);
        expect_at(6, K_EN, 0, 1);
        expect_at(6, K_OSC, 1, 1);
        step(2);

        // R8: divided output at L=7
        div_sel = 1'b1;
        osc_en = 1'b1;
        expect_at(8, K_OSC, 0, 13);
        expect_at(8, K_OSC, 1, 14);
        expect_at(8, K_OSC, 1, 27);
        expect_at(8, K_OSC, 0, 28);
        step(30);
        div_sel = 1'b0;
        expect_at(10, K_OSC, 1, 1);   // R10 ring level shown at once
        step(1);
        div_sel = 1'b1;
        expect_at(10, K_OSC, 0, 1);   // R10 divided level shown at once
        expect_at(8, K_OSC, 1, 12);
        step(13);
        osc_en = 1'b0;
        expect_at(9, K_OSC, 0, 1);    // R9 cleared on disable
        step(2);
        div_sel = 1'b0;

        // R7: longest loop
        wr_len(255);
        step(2);
        osc_en = 1'b1;
        expect_at(4, K_GATE, 127, 1);
        expect_at(7, K_OSC, 1, 254);
        expect_at(7, K_OSC, 0, 255);
        step(257);
        osc_en = 1'b0;
        step(2);

        // R7: shortest loop
        wr_len(3);
        step(2);
        osc_en = 1'b1;
        expect_at(4, K_GATE, 1, 1);
        expect_at(7, K_OSC, 1, 2);
        expect_at(7, K_OSC, 0, 3);
        expect_at(7, K_OSC, 1, 6);
        step(8);
        osc_en = 1'b0;
        step(3);

        if (q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard actual=%0d expected=0 pending items", q.size());
        end
        summary();
    end

endmodule